// File: doc/BRIEF.md
# Vector Compare and Select Unit

This block carries out the comparison-flavoured operations of a four-lane shader ALU that works on 24-bit floating-point values. There are two selection operations, MIN and MAX. There are two set operations that produce 1.0 or 0.0 in each lane, set-if-greater-or-equal (SGE) and set-if-less-than (SLT). The fifth operation, CMP, evaluates the first two lanes and stores the outcomes as two condition bits. The caller supplies two operand vectors that are already swizzled and negated, an opcode, a per-lane write mask and two 3-bit compare modes. Results are stored in registers and are valid one cycle later.

Each lane holds its value until an operation writes it, so the masked lanes of a destination keep their old contents. The two condition bits also hold until a CMP with a defined mode overwrites them. NaN ordering is fixed on purpose. MIN and MAX return the second operand whenever the strict comparison is false, so the NaN outcome depends on which side the NaN sits.

A small controller with the states IDLE and EMIT drives `out_valid`. It has four transitions: ACCEPT (IDLE to EMIT on `in_valid`), STREAM (EMIT stays in EMIT on `in_valid`), DRAIN (EMIT to IDLE without `in_valid`) and WAIT (IDLE stays in IDLE without `in_valid`).

Top module: `vec_cmp_sel`

## Requirements
- R1: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` = 1. Without `in_valid`, `result` and `cond` do not change. Back-to-back requests give back-to-back results.
- R2: While `rst_n` = 0, `out_valid`, `result` and `cond` are all zero.
- R3: Opcode 1 (MAX) writes a when a > b and writes b otherwise. So max(0,NaN) = NaN and max(NaN,0) = 0.
- R4: Opcode 0 (MIN) writes a when a < b and writes b otherwise. So min(0,NaN) = NaN and min(NaN,0) = 0.
- R5: Opcode 2 (SGE) writes 1.0 (0x3F0000) when a >= b and 0x000000 otherwise.
- R6: Opcode 3 (SLT) writes 1.0 when a < b and 0x000000 otherwise.
- R7: Lane i occupies bits [24i+23:24i], with lane x at i = 0. A lane whose `wr_mask[i]` is 0 keeps its previous value.
- R8: Opcode 4 (CMP) sets `cond[0]` from lane x using `mode_x` and `cond[1]` from lane y using `mode_y`. The mode codes are 0 equal, 1 not-equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. CMP does not alter `result`, and no other opcode alters `cond`.
- R9: A mode of 6 or 7 leaves the corresponding condition bit unchanged.
- R10: The value format is sign in bit 23, a 7-bit exponent in bits 22:16 with bias 63, and the mantissa in bits 15:0. A NaN has exponent 127 and a non-zero mantissa. Every comparison involving a NaN is false except not-equal, which is true. +0 and -0 compare equal.
- R11: Opcodes 5 to 7 change neither `result` nor `cond`, but `out_valid` still rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 96 | First operand, four lanes |
| in_b | input | 96 | Second operand, four lanes |
| wr_mask | input | 4 | Per-lane destination enable |
| mode_x | input | 3 | Compare mode for condition bit 0 |
| mode_y | input | 3 | Compare mode for condition bit 1 |
| out_valid | output | 1 | Result valid strobe |
| result | output | 96 | Registered lane values |
| cond | output | 2 | Registered condition bits |

## Verification
A fault in the lane registers shows on `result` in the cycle right after the request, because every lane feeds the port directly. A fault in the condition registers shows on `cond` within the same single cycle. A wrongly ordered comparator gives a wrong lane value or a wrong condition bit on the next `out_valid`. Masked lanes and unchanged condition bits are checked at the ports on the following cycle. A corrupted controller state shows as `out_valid` that is missing, stuck or extended by one cycle.

// File: rtl/vcs_pkg.sv
`timescale 1ns/1ps
package vcs_pkg;

    typedef enum logic [2:0] {
        OP_MIN = 3'd0,
        OP_MAX = 3'd1,
        OP_SGE = 3'd2,
        OP_SLT = 3'd3,
        OP_CMP = 3'd4
    } vcs_op_e;

    typedef enum logic [2:0] {
        CM_EQ = 3'd0,
        CM_NE = 3'd1,
        CM_LT = 3'd2,
        CM_LE = 3'd3,
        CM_GT = 3'd4,
        CM_GE = 3'd5
    } vcs_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vcs_state_e;

endpackage

// File: rtl/vcs_fp_cmp.sv
`timescale 1ns/1ps
// Ordered comparison of two sign-magnitude floats.
module vcs_fp_cmp #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output logic                 lt,
    output logic                 eq,
    output logic                 unord
);
    localparam int W   = 1 + EXP_W + MAN_W;
    localparam int MAG = W - 1;

    logic            a_nan, b_nan, both_zero, mag_lt, mag_gt, lt_raw;
    logic [MAG-1:0]  a_mag, b_mag;

    always_comb begin
        a_mag     = a[MAG-1:0];
        b_mag     = b[MAG-1:0];
        a_nan     = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
        b_nan     = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
        unord     = a_nan || b_nan;
        both_zero = (a_mag == '0) && (b_mag == '0);
        mag_lt    = a_mag < b_mag;
        mag_gt    = a_mag > b_mag;
        unique case ({a[W-1], b[W-1]})
            2'b10:   lt_raw = !both_zero;
            2'b01:   lt_raw = 1'b0;
            2'b00:   lt_raw = mag_lt;
            default: lt_raw = mag_gt;
        endcase
        eq = !unord && ((a == b) || both_zero);
        lt = !unord && lt_raw;
    end
endmodule

// File: rtl/vcs_lane_sel.sv
`timescale 1ns/1ps
// Next value of one lane for the selecting and setting operations.
module vcs_lane_sel
    import vcs_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input  logic [2:0]           in_op,
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  logic                 lt,
    input  logic                 eq,
    input  logic                 unord,
    output logic [EXP_W+MAN_W:0] nxt
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] ONE = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    logic gt, ge;

    always_comb begin
        gt = !lt && !eq && !unord;
        ge = gt || eq;
        unique case (in_op)
            OP_MIN:  nxt = lt ? a : b;
            OP_MAX:  nxt = gt ? a : b;
            OP_SGE:  nxt = ge ? ONE : '0;
            OP_SLT:  nxt = lt ? ONE : '0;
            default: nxt = a;
        endcase
    end
endmodule

// File: rtl/vcs_cc_eval.sv
`timescale 1ns/1ps
// Evaluates one condition bit under a 3-bit compare mode.
module vcs_cc_eval
    import vcs_pkg::*;
(
    input  logic       lt,
    input  logic       eq,
    input  logic       unord,
    input  logic [2:0] mode,
    output logic       hit,
    output logic       val
);
    logic gt;

    always_comb begin
        gt  = !lt && !eq && !unord;
        hit = 1'b1;
        unique case (mode)
            CM_EQ:   val = eq;
            CM_NE:   val = !eq;
            CM_LT:   val = lt;
            CM_LE:   val = lt || eq;
            CM_GT:   val = gt;
            CM_GE:   val = gt || eq;
            default: begin
                hit = 1'b0;
                val = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vcs_ctrl.sv
`timescale 1ns/1ps
// Output-valid controller.
module vcs_ctrl
    import vcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    vcs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;  // ACCEPT / WAIT
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;  // STREAM / DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/vec_cmp_sel.sv
`timescale 1ns/1ps
module vec_cmp_sel
    import vcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [2:0]                         in_op,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0]   in_a,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0]   in_b,
    input  logic [LANES-1:0]                   wr_mask,
    input  logic [2:0]                         mode_x,
    input  logic [2:0]                         mode_y,
    output logic                               out_valid,
    output logic [LANES*(1+EXP_W+MAN_W)-1:0]   result,
    output logic [1:0]                         cond
);
    localparam int LW      = 1 + EXP_W + MAN_W;
    localparam int CC_BITS = 2;

    logic             is_cmp, is_write;
    logic [LANES-1:0] lt_v, eq_v, un_v;
    logic [2:0]       cc_mode [CC_BITS];

    assign is_cmp     = (in_op == OP_CMP);
    assign is_write   = (in_op == OP_MIN) || (in_op == OP_MAX) ||
                        (in_op == OP_SGE) || (in_op == OP_SLT);
    assign cc_mode[0] = mode_x;
    assign cc_mode[1] = mode_y;

    vcs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0] a_l, b_l, nxt, q;
        logic          lt, eq, un;

        assign a_l = in_a[i*LW +: LW];
        assign b_l = in_b[i*LW +: LW];

        vcs_fp_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
            .a     (a_l),
            .b     (b_l),
            .lt    (lt),
            .eq    (eq),
            .unord (un)
        );

        vcs_lane_sel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
            .in_op (in_op),
            .a     (a_l),
            .b     (b_l),
            .lt    (lt),
            .eq    (eq),
            .unord (un),
            .nxt   (nxt)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    q <= '0;
            else if (in_valid && is_write && wr_mask[i])   q <= nxt;
        end

        assign result[i*LW +: LW] = q;
        assign lt_v[i] = lt;
        assign eq_v[i] = eq;
        assign un_v[i] = un;
    end

    for (genvar j = 0; j < CC_BITS; j++) begin : g_cc
        logic hit, val, q;

        vcs_cc_eval u_eval (
            .lt    (lt_v[j]),
            .eq    (eq_v[j]),
            .unord (un_v[j]),
            .mode  (cc_mode[j]),
            .hit   (hit),
            .val   (val)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           q <= 1'b0;
            else if (in_valid && is_cmp && hit)   q <= val;
        end

        assign cond[j] = q;
    end
endmodule

// File: rtl/vec_cmp_sel_chk.sv
`timescale 1ns/1ps
module vec_cmp_sel_chk
    import vcs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_valid,
    input logic [2:0]                       in_op,
    input logic [LANES*(1+EXP_W+MAN_W)-1:0] in_a,
    input logic [LANES*(1+EXP_W+MAN_W)-1:0] in_b,
    input logic [LANES-1:0]                 wr_mask,
    input logic [2:0]                       mode_x,
    input logic [2:0]                       mode_y,
    input logic                             out_valid,
    input logic [LANES*(1+EXP_W+MAN_W)-1:0] result,
    input logic [1:0]                       cond
);
    localparam int LW = 1 + EXP_W + MAN_W;
    localparam logic [LW-1:0] ONE = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cond)));

    assert_cmp_keeps_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMP) |=> $stable(result));

    assert_cond_only_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != OP_CMP) |=> $stable(cond));

    assert_mode_x_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMP && mode_x > 3'd5) |=> $stable(cond[0]));

    assert_mode_y_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMP && mode_y > 3'd5) |=> $stable(cond[1]));

    assert_undef_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 3'd4) |=> ($stable(result) && $stable(cond) && out_valid));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        assert_masked_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !wr_mask[i]) |=> $stable(result[i*LW +: LW]));

        assert_set_is_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && wr_mask[i] && (in_op == OP_SGE || in_op == OP_SLT)) |=>
            (result[i*LW +: LW] == '0 || result[i*LW +: LW] == ONE));

        assert_pick_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && wr_mask[i] && (in_op == OP_MIN || in_op == OP_MAX)) |=>
            (result[i*LW +: LW] == $past(in_a[i*LW +: LW]) ||
             result[i*LW +: LW] == $past(in_b[i*LW +: LW])));
    end
endmodule

bind vec_cmp_sel vec_cmp_sel_chk #(.LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .wr_mask   (wr_mask),
    .mode_x    (mode_x),
    .mode_y    (mode_y),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond)
);

// File: tb/vec_cmp_sel_tb.sv
`timescale 1ns/1ps
module vec_cmp_sel_tb;
    localparam int VW = 96;
    localparam int NV = 12;

    typedef struct packed {
        logic [2:0]    op;
        logic [3:0]    mask;
        logic [2:0]    mx;
        logic [2:0]    my;
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        logic [VW-1:0] er;
        logic [1:0]    ec;
    } vec_t;

    // Lanes written {w, z, y, x}. 1.0=3F0000 2.0=400000 0.5=3E0000 -1=BF0000
    // -0=800000 NaN=7F0001/7FFFFF +inf=7F0000 -inf=FF0000 3.0=408000 -2=C00000
    localparam vec_t TBL [NV] = '{
        // R3 MAX with NaN on either side
        '{3'd1, 4'hF, 3'd7, 3'd7,
          {24'h7F0001, 24'h000000, 24'hBF0000, 24'h3F0000},
          {24'h000000, 24'h7F0001, 24'h3E0000, 24'h400000},
          {24'h000000, 24'h7F0001, 24'h3E0000, 24'h400000}, 2'b00},
        // R4 MIN with NaN on either side
        '{3'd0, 4'hF, 3'd7, 3'd7,
          {24'h7F0001, 24'h000000, 24'hBF0000, 24'h3F0000},
          {24'h000000, 24'h7F0001, 24'h3E0000, 24'h400000},
          {24'h000000, 24'h7F0001, 24'hBF0000, 24'h3F0000}, 2'b00},
        // R3 R10 MAX on signed zeros and infinity
        '{3'd1, 4'hF, 3'd7, 3'd7,
          {24'hBF0000, 24'h7F0000, 24'h000000, 24'h800000},
          {24'h800000, 24'h3F0000, 24'h800000, 24'h000000},
          {24'h800000, 24'h7F0000, 24'h800000, 24'h000000}, 2'b00},
        // R5 SGE
        '{3'd2, 4'hF, 3'd7, 3'd7,
          {24'h800000, 24'h7F0001, 24'h3E0000, 24'h3F0000},
          {24'h000000, 24'h000000, 24'h400000, 24'h3F0000},
          {24'h3F0000, 24'h000000, 24'h000000, 24'h3F0000}, 2'b00},
        // R6 SLT
        '{3'd3, 4'hF, 3'd7, 3'd7,
          {24'h800000, 24'h7F0001, 24'h3E0000, 24'h3F0000},
          {24'h000000, 24'h000000, 24'h400000, 24'h3F0000},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b00},
        // R8 R10 CMP x:EQ(-0,+0) y:LT
        '{3'd4, 4'hF, 3'd0, 3'd2,
          {24'h0, 24'h0, 24'hBF0000, 24'h800000},
          {24'h0, 24'h0, 24'h3F0000, 24'h000000},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b11},
        // R8 R10 CMP x:NE(NaN,NaN) y:GE(NaN,0)
        '{3'd4, 4'hF, 3'd1, 3'd5,
          {24'h0, 24'h0, 24'h7F0001, 24'h7FFFFF},
          {24'h0, 24'h0, 24'h000000, 24'h7FFFFF},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b01},
        // R8 CMP x:GT y:LE
        '{3'd4, 4'hF, 3'd4, 3'd3,
          {24'h0, 24'h0, 24'h3F0000, 24'h400000},
          {24'h0, 24'h0, 24'h3F0000, 24'h3F0000},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b11},
        // R9 CMP with both modes undefined
        '{3'd4, 4'hF, 3'd6, 3'd7,
          {24'h0, 24'h0, 24'h0, 24'h0},
          {24'h0, 24'h0, 24'h0, 24'h0},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b11},
        // R8 R10 CMP x:LT(-1,-0) y:EQ(NaN,NaN)
        '{3'd4, 4'hF, 3'd2, 3'd0,
          {24'h0, 24'h0, 24'h7F0001, 24'hBF0000},
          {24'h0, 24'h0, 24'h7F0001, 24'h800000},
          {24'h000000, 24'h000000, 24'h3F0000, 24'h000000}, 2'b01},
        // R3 MAX on negatives and infinities
        '{3'd1, 4'hF, 3'd7, 3'd7,
          {24'hFF0000, 24'h000000, 24'h408000, 24'hBF0000},
          {24'hBF0000, 24'h7F0000, 24'h400000, 24'hC00000},
          {24'hBF0000, 24'h7F0000, 24'h408000, 24'hBF0000}, 2'b01},
        // R11 undefined opcode 5
        '{3'd5, 4'hF, 3'd0, 3'd0,
          {24'h3F0000, 24'h3F0000, 24'h3F0000, 24'h3F0000},
          {24'h0, 24'h0, 24'h0, 24'h0},
          {24'hBF0000, 24'h7F0000, 24'h408000, 24'hBF0000}, 2'b01}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic [3:0]    wr_mask = '0;
    logic [2:0]    mode_x = 3'd7;
    logic [2:0]    mode_y = 3'd7;
    logic          out_valid;
    logic [VW-1:0] result;
    logic [1:0]    cond;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_cmp_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .wr_mask   (wr_mask),
        .mode_x    (mode_x),
        .mode_y    (mode_y),
        .out_valid (out_valid),
        .result    (result),
        .cond      (cond)
    );

    task automatic chk_vec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bits(string req, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] op, logic [3:0] m, logic [2:0] mx, logic [2:0] my,
                         logic [VW-1:0] a, logic [VW-1:0] b);
        in_op = op; wr_mask = m; mode_x = mx; mode_y = my; in_a = a; in_b = b;
        in_valid = 1'b1;
    endtask

    task automatic issue(logic [2:0] op, logic [3:0] m, logic [2:0] mx, logic [2:0] my,
                         logic [VW-1:0] a, logic [VW-1:0] b);
        @(negedge clk);
        drive(op, m, mx, my, a, b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk_bits("R2", "out_valid", {1'b0, out_valid}, 2'b00);
        chk_vec("R2", result, '0);
        chk_bits("R2", "cond", cond, 2'b00);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            issue(TBL[k].op, TBL[k].mask, TBL[k].mx, TBL[k].my, TBL[k].a, TBL[k].b);
            chk_bits("R1", "out_valid", {1'b0, out_valid}, 2'b01);
            chk_vec($sformatf("R3-table%0d", k), result, TBL[k].er);
            chk_bits($sformatf("R8-table%0d", k), "cond", cond, TBL[k].ec);
        end

        // R7 partial mask: only lanes x and z written by MIN
        issue(3'd0, 4'b0101, 3'd7, 3'd7, {4{24'h3F0000}}, {4{24'h400000}});
        chk_vec("R7", result, {24'hBF0000, 24'h3F0000, 24'h408000, 24'h3F0000});
        // R7 empty mask
        issue(3'd1, 4'b0000, 3'd7, 3'd7, {4{24'h7F0000}}, {4{24'h7F0000}});
        chk_vec("R7", result, {24'hBF0000, 24'h3F0000, 24'h408000, 24'h3F0000});
        chk_bits("R1", "out_valid", {1'b0, out_valid}, 2'b01);

        // R1 back-to-back: SLT then SGE on equal operands
        @(negedge clk);
        drive(3'd3, 4'hF, 3'd7, 3'd7, '0, '0);
        @(negedge clk);
        chk_bits("R1", "out_valid", {1'b0, out_valid}, 2'b01);
        chk_vec("R6", result, '0);
        drive(3'd2, 4'hF, 3'd7, 3'd7, '0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_bits("R1", "out_valid", {1'b0, out_valid}, 2'b01);
        chk_vec("R5", result, {4{24'h3F0000}});
        @(negedge clk);
        chk_bits("R1", "out_valid", {1'b0, out_valid}, 2'b00);
        chk_vec("R1", result, {4{24'h3F0000}});
        chk_bits("R1", "cond", cond, 2'b01);

        // R2 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        chk_vec("R2", result, '0);
        chk_bits("R2", "cond", cond, 2'b00);
        chk_bits("R2", "out_valid", {1'b0, out_valid}, 2'b00);
        rst_n = 1'b1;

        // R9 mode_y undefined keeps bit 1, x:LT sets bit 0
        issue(3'd4, 4'hF, 3'd2, 3'd6, {24'h0, 24'h0, 24'h3F0000, 24'hBF0000},
              {24'h0, 24'h0, 24'h3F0000, 24'h3F0000});
        chk_bits("R9", "cond", cond, 2'b01);
        // R10 +0 == -0 on y, x undefined keeps bit 0
        issue(3'd4, 4'hF, 3'd7, 3'd0, {24'h0, 24'h0, 24'h000000, 24'h0},
              {24'h0, 24'h0, 24'h800000, 24'h0});
        chk_bits("R10", "cond", cond, 2'b11);
        chk_vec("R8", result, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule